// File: doc/BRIEF.md
# Next-PC Target Generator

This block sits in the fetch stage of a 32-bit processor with fixed 4-byte instructions. Each cycle it takes the current fetch address and the fields of a decoded control-flow instruction. These are a signed 16-bit word displacement, a 26-bit direct-jump index and a register-supplied target. It also takes an already evaluated branch condition and a two-bit control-flow kind. From these it produces the address to fetch next.

It also supplies the address following the current instruction as a link value, so that calls can save it in a return-address register. Register targets that are not word aligned raise a fault flag instead of steering the fetch unit.

All outputs are registered. A result appears one clock edge after its inputs are sampled.

Top module: `npc_target_gen`

## Requirements
- R1: While `rst_n` is low, `next_pc`, `link_addr`, `redirect`, `link_valid` and `align_fault` are all zero.
- R2: With `flow_kind` = 0 (sequential), `next_pc` is `cur_pc` + 4 and `redirect` is 0.
- R3: With `flow_kind` = 1 (conditional branch) and `cond_true` = 1, `next_pc` is (`cur_pc` + 4) plus `br_disp` sign-extended and multiplied by four, modulo 2^32.
- R4: With `flow_kind` = 1 and `cond_true` = 0, `next_pc` is `cur_pc` + 4. For every other kind, `cond_true` has no effect on any output.
- R5: With `flow_kind` = 2 (direct jump), `next_pc` is bits 31..28 of `cur_pc` (not of `cur_pc` + 4), then the 26 bits of `jmp_index`, then two zero bits.
- R6: With `flow_kind` = 3 (register jump) and `reg_target[1:0]` = 0, `next_pc` equals `reg_target`.
- R7: With `flow_kind` = 3 and `reg_target[1:0]` nonzero, `align_fault` is 1, `next_pc` is `cur_pc` + 4, and both `redirect` and `link_valid` are 0. In all other cases `align_fault` is 0.
- R8: `redirect` is 1 exactly when `next_pc` differs from `cur_pc` + 4. This means a taken branch with zero displacement does not redirect.
- R9: `link_addr` is always `cur_pc` + 4. `link_valid` is 1 only when `link_req` is 1, `flow_kind` is 2 or 3, and no alignment fault is raised. `link_req` is ignored for kinds 0 and 1.
- R10: Every output reflects the inputs sampled at the previous rising clock edge and stays unchanged between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_pc | input | 32 | Address of the current instruction |
| br_disp | input | 16 | Signed branch displacement in words |
| jmp_index | input | 26 | Direct-jump word index |
| reg_target | input | 32 | Register-supplied jump target |
| cond_true | input | 1 | Branch condition result |
| flow_kind | input | 2 | 0 sequential, 1 branch, 2 jump, 3 register jump |
| link_req | input | 1 | Instruction is a call and wants a link value |
| next_pc | output | 32 | Address to fetch next |
| redirect | output | 1 | Fetch leaves the sequential path |
| link_addr | output | 32 | Return address (`cur_pc` + 4) |
| link_valid | output | 1 | `link_addr` should be written back |
| align_fault | output | 1 | Register target not word aligned |

## Verification
Every result is due exactly one rising edge after its inputs are applied. The bench therefore drives a vector on a falling edge and reads all five outputs on the next falling edge, halfway after the single register stage.

A separate probe reads the outputs one nanosecond after a new vector is driven. At that point they must still hold the previous result, which shows that nothing passes through without the register.

The sweep covers every kind, condition, link request and alignment pattern. It runs across fetch addresses at the region edges and the address-space wrap, and across displacements at both signed extremes.

// File: rtl/npc_pkg.sv
package npc_pkg;
   typedef enum logic [1:0] {
      FLOW_SEQ    = 2'd0,
      FLOW_BRANCH = 2'd1,
      FLOW_JUMP   = 2'd2,
      FLOW_JREG   = 2'd3
   } flow_kind_t;
endpackage

// File: rtl/npc_branch_calc.sv
module npc_branch_calc #(
   parameter int ADDR_W  = 32,
   parameter int DISP_W  = 16,
   parameter int ALIGN_B = 2
) (
   input  logic [ADDR_W-1:0] seq_pc,
   input  logic [DISP_W-1:0] disp,
   output logic [ADDR_W-1:0] target
);
   localparam int EXT_W = ADDR_W - DISP_W - ALIGN_B;

   initial begin
      if (EXT_W < 1) $error("npc_branch_calc: displacement too wide for address");
   end

   logic [ADDR_W-1:0] offset;
   assign offset = {{EXT_W{disp[DISP_W-1]}}, disp, {ALIGN_B{1'b0}}};
   assign target = seq_pc + offset;
endmodule

// File: rtl/npc_jump_calc.sv
module npc_jump_calc #(
   parameter int IDX_W   = 26,
   parameter int SEG_W   = 4,
   parameter int ALIGN_B = 2
) (
   input  logic [SEG_W-1:0]               pc_seg,
   input  logic [IDX_W-1:0]               index,
   output logic [SEG_W+IDX_W+ALIGN_B-1:0] target
);
   initial begin
      if (SEG_W < 1) $error("npc_jump_calc: no region bits left");
   end

   assign target = {pc_seg, index, {ALIGN_B{1'b0}}};
endmodule

// File: rtl/npc_select.sv
module npc_select
   import npc_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int ALIGN_B = 2,
   parameter int SEG_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  flow_kind_t        kind,
   input  logic              cond_true,
   input  logic              link_req,
   input  logic [ADDR_W-1:0] cur_pc,
   input  logic [ADDR_W-1:0] seq_pc,
   input  logic [ADDR_W-1:0] br_target,
   input  logic [ADDR_W-1:0] jmp_target,
   input  logic [ADDR_W-1:0] reg_target,
   output logic [ADDR_W-1:0] npc,
   output logic              redir,
   output logic              fault,
   output logic              link_ok
);
   logic misaligned;
   assign misaligned = |reg_target[ALIGN_B-1:0];

   always_comb begin
      npc   = seq_pc;
      fault = 1'b0;
      unique case (kind)
         FLOW_SEQ:    npc = seq_pc;
         FLOW_BRANCH: if (cond_true) npc = br_target;
         FLOW_JUMP:   npc = jmp_target;
         FLOW_JREG: begin
            if (misaligned) fault = 1'b1;
            else            npc   = reg_target;
         end
         default:     npc = seq_pc;
      endcase
   end

   assign redir   = (npc != seq_pc);
   assign link_ok = link_req && (kind == FLOW_JUMP || kind == FLOW_JREG) && !fault;

   // R7
   fault_no_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> !redir && !link_ok);
   // R2
   seq_no_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == FLOW_SEQ) |-> !redir);
   // R5
   jump_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == FLOW_JUMP) |-> npc[ADDR_W-1 -: SEG_W] == cur_pc[ADDR_W-1 -: SEG_W]);
   // R4
   not_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == FLOW_BRANCH && !cond_true) |-> npc == seq_pc);
endmodule

// File: rtl/npc_target_gen.sv
module npc_target_gen
   import npc_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int DISP_W  = 16,
   parameter int IDX_W   = 26,
   parameter int INSTR_B = 4,
   parameter bit REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [31:0]       cur_pc,
   input  logic [15:0]       br_disp,
   input  logic [25:0]       jmp_index,
   input  logic [31:0]       reg_target,
   input  logic              cond_true,
   input  logic [1:0]        flow_kind,
   input  logic              link_req,
   output logic [31:0]       next_pc,
   output logic              redirect,
   output logic [31:0]       link_addr,
   output logic              link_valid,
   output logic              align_fault
);
   localparam int ALIGN_B = $clog2(INSTR_B);
   localparam int SEG_W   = ADDR_W - IDX_W - ALIGN_B;

   initial begin
      if (ADDR_W != 32 || DISP_W != 16 || IDX_W != 26)
         $error("npc_target_gen: port widths fixed at 32/16/26");
      if (INSTR_B != (1 << ALIGN_B)) $error("npc_target_gen: INSTR_B must be a power of two");
      if (SEG_W < 1) $error("npc_target_gen: jump index leaves no region bits");
   end

   flow_kind_t        kind;
   logic [ADDR_W-1:0] seq_pc, br_tgt, jmp_tgt, npc_c;
   logic              redir_c, fault_c, link_c;

   assign kind   = flow_kind_t'(flow_kind);
   assign seq_pc = cur_pc + ADDR_W'(INSTR_B);

   npc_branch_calc #(.ADDR_W(ADDR_W), .DISP_W(DISP_W), .ALIGN_B(ALIGN_B)) i_branch (
      .seq_pc (seq_pc),
      .disp   (br_disp),
      .target (br_tgt)
   );

   npc_jump_calc #(.IDX_W(IDX_W), .SEG_W(SEG_W), .ALIGN_B(ALIGN_B)) i_jump (
      .pc_seg (cur_pc[ADDR_W-1 -: SEG_W]),
      .index  (jmp_index),
      .target (jmp_tgt)
   );

   npc_select #(.ADDR_W(ADDR_W), .ALIGN_B(ALIGN_B), .SEG_W(SEG_W)) i_select (
      .clk        (clk),
      .rst_n      (rst_n),
      .kind       (kind),
      .cond_true  (cond_true),
      .link_req   (link_req),
      .cur_pc     (cur_pc),
      .seq_pc     (seq_pc),
      .br_target  (br_tgt),
      .jmp_target (jmp_tgt),
      .reg_target (reg_target),
      .npc        (npc_c),
      .redir      (redir_c),
      .fault      (fault_c),
      .link_ok    (link_c)
   );

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               next_pc     <= '0;
               redirect    <= 1'b0;
               link_addr   <= '0;
               link_valid  <= 1'b0;
               align_fault <= 1'b0;
            end else begin
               next_pc     <= npc_c;
               redirect    <= redir_c;
               link_addr   <= seq_pc;
               link_valid  <= link_c;
               align_fault <= fault_c;
            end
         end
      end else begin : g_comb
         assign next_pc     = npc_c;
         assign redirect    = redir_c;
         assign link_addr   = seq_pc;
         assign link_valid  = link_c;
         assign align_fault = fault_c;
      end
   endgenerate

   // R7
   fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({redirect, align_fault}));
endmodule

// File: tb/test_npc_target_gen.sv
module test_npc_target_gen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] cur_pc = '0, reg_target = '0;
   logic [15:0] br_disp = '0;
   logic [25:0] jmp_index = '0;
   logic        cond_true = 1'b0, link_req = 1'b0;
   logic [1:0]  flow_kind = '0;
   logic [31:0] next_pc, link_addr;
   logic        redirect, link_valid, align_fault;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   npc_target_gen i_npc_target_gen (
      .clk(clk), .rst_n(rst_n), .cur_pc(cur_pc), .br_disp(br_disp),
      .jmp_index(jmp_index), .reg_target(reg_target), .cond_true(cond_true),
      .flow_kind(flow_kind), .link_req(link_req), .next_pc(next_pc),
      .redirect(redirect), .link_addr(link_addr), .link_valid(link_valid),
      .align_fault(align_fault)
   );

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h (pc=%h kind=%0d)", tag, act, exp, cur_pc, flow_kind);
      end
   endtask

   function automatic logic [31:0] pc_pick(int i);
      case (i)
         0: return 32'h0000_0000;
         1: return 32'h0FFF_FFFC;
         2: return 32'h1000_0000;
         3: return 32'h8765_4320;
         4: return 32'hFFFF_FFFC;
         default: return 32'h7FFF_0010;
      endcase
   endfunction

   function automatic logic [15:0] disp_pick(int i);
      case (i)
         0: return 16'h0000;
         1: return 16'h0001;
         2: return 16'hFFFF;
         3: return 16'h7FFF;
         4: return 16'h8000;
         default: return 16'h1234;
      endcase
   endfunction

   initial begin
      #700000;
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      // R1: reset holds outputs at zero even with active inputs
      cur_pc = 32'h1000_0000; flow_kind = 2'd3; reg_target = 32'h4; link_req = 1'b1;
      repeat (3) @(negedge clk);
      check("R1 next_pc", next_pc, 32'h0);
      check("R1 link_addr", link_addr, 32'h0);
      check("R1 flags", {29'd0, redirect, link_valid, align_fault}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // R10: an output must not change until the next rising edge
      cur_pc = 32'h2000_0000; flow_kind = 2'd2; jmp_index = 26'h0AB_CDEF;
      link_req = 1'b0;
      @(negedge clk);
      check("R10 settled", next_pc, 32'h22AF_37BC);
      cur_pc = 32'h3000_0000; flow_kind = 2'd0;
      #1;
      check("R10 held", next_pc, 32'h22AF_37BC);
      @(negedge clk);
      check("R10 updated", next_pc, 32'h3000_0004);

      for (int p = 0; p < 6; p++)
         for (int d = 0; d < 6; d++)
            for (int k = 0; k < 4; k++)
               for (int c = 0; c < 2; c++)
                  for (int l = 0; l < 2; l++)
                     for (int r = 0; r < 4; r++) begin
                        logic [31:0] seq, exp_pc, rt;
                        logic [25:0] idx;
                        logic        exp_f, exp_l;
                        string       tag;
                        rt  = {pc_pick(5 - p)} ^ {disp_pick(d), 16'h0} | 32'(r);
                        rt[1:0] = 2'(r);
                        idx = {disp_pick(d), 10'h2A5} ^ 26'(p * 26'h0135_79B);
                        cur_pc = pc_pick(p); br_disp = disp_pick(d); jmp_index = idx;
                        reg_target = rt; flow_kind = 2'(k); cond_true = c[0]; link_req = l[0];
                        seq = pc_pick(p) + 32'd4;
                        exp_pc = seq; exp_f = 1'b0;
                        case (k)
                           0: tag = "R2";
                           1: if (c == 1) begin
                                 tag = "R3";
                                 exp_pc = seq + 32'($signed(disp_pick(d))) * 32'd4;
                              end else tag = "R4";
                           2: begin tag = "R5"; exp_pc = {pc_pick(p)[31:28], idx, 2'b00}; end
                           default: if (r != 0) begin tag = "R7"; exp_f = 1'b1; end
                                    else begin tag = "R6"; exp_pc = rt; end
                        endcase
                        exp_l = (l == 1) && (k >= 2) && !exp_f;
                        @(negedge clk);  // R10: result due one rising edge later
                        check(tag, next_pc, exp_pc);
                        check("R8 redirect", {31'd0, redirect}, {31'd0, exp_pc != seq});
                        check("R7 align_fault", {31'd0, align_fault}, {31'd0, exp_f});
                        check("R9 link_valid", {31'd0, link_valid}, {31'd0, exp_l});
                        check("R9 link_addr", link_addr, seq);
                     end
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule